// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause 22 station-management master with a small register interface. Software formats a complete management frame as one 32-bit word and writes it to the data register. That write launches the transaction. The block sends a 32-bit preamble of ones, then shifts the command word out MSB first on the MDIO line. It also generates MDC from the system clock, using a programmable 6-bit divider.

For a read frame, the block releases MDIO from the second turnaround bit to the end of the frame. It samples the PHY's 16 data bits on rising MDC edges and places them in the low half of the data register. When a frame ends, the block raises a completion event that software clears by writing one to it. A busy status bit stays readable while the frame runs. A command is refused if management is disabled, if the divider is zero, or if a frame is already in flight.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero. MDC is low, MDIO output enable is low and the busy bit is 0.
- R2: The register map uses word address 0 for control (bit 0 enables management), 1 for event/status (bit 0 completion event, bit 1 busy), 2 for speed and 3 for data. The speed divider sits in bits 6:1, and all other speed bits read as zero.
- R3: A data-register write is accepted when management is enabled, the divider is nonzero and the block is idle. The word is stored, and busy reads 1 from the next cycle on.
- R4: Each MDC period lasts 2×divider system clocks, with the low half first. MDC stays low whenever no frame is active.
- R5: The bits on MDIO are 32 ones followed by command bits 31 down to 0. MDIO changes only on a falling MDC edge.
- R6: Output enable is high for every bit of a write frame (opcode bits 29:28 = 01). For a read frame (opcode 10), it is low from frame bit 16 (the second turnaround bit, serial position 47) through the last bit, and it is low while idle.
- R7: For a read, the PHY bits present at the rising MDC edges of the last 16 positions are captured MSB first. On completion they replace data bits 15:0, and bits 31:16 keep the command.
- R8: At the falling MDC edge that closes the 64th bit, busy clears and the completion event sets, 128×divider clocks after the accepting edge.
- R9: Writing 1 to event bit 0 clears it. Writing 0 leaves it set.
- R10: With management disabled, a data write does not start a frame and leaves the data register unchanged.
- R11: With a zero divider, a data write does not start a frame and MDC stays low.
- R12: A data write while busy is ignored. The frame in progress and the data register are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen from the line |

## Verification
The bench targets the read turnaround boundary. A design that releases MDIO one bit late or early shows a wrong enable at serial position 47 or 46. It also targets the completion edge: an off-by-one in the bit counter or divider shifts the busy length away from 128×divider clocks. A data write in mid-frame must not corrupt the shifting word or the stored command. Refused commands (management disabled, divider zero) must leave MDC still and the data register untouched. A divider of one, where every system clock is an MDC edge, is exercised along with larger dividers.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_EVENT = 2'd1;
  localparam logic [1:0] ADDR_SPEED = 2'd2;
  localparam logic [1:0] ADDR_DATA  = 2'd3;
  localparam logic [1:0] OP_READ    = 2'b10;

  typedef struct packed {
    logic load;     // accept a command word
    logic advance;  // move to next serial bit (falling MDC)
    logic sample;   // capture MDIO (rising MDC, read data phase)
    logic finish;   // frame complete
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_master_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_LEN = 32,
  parameter int RD_BITS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       strobe,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic              mdioIn,
  output logic [DATA_W-1:0] dataReg,
  output logic              serialBit,
  output logic              isRead
);
  localparam int SHIFT_W = PRE_LEN + DATA_W;

  logic [SHIFT_W-1:0] shiftReg;
  logic [RD_BITS-1:0] capture;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      dataReg  <= '0;
      capture  <= '0;
    end else begin
      if (strobe.load) begin
        shiftReg <= {{PRE_LEN{1'b1}}, cmdWord};
        dataReg  <= cmdWord;
      end else if (strobe.advance) begin
        shiftReg <= {shiftReg[SHIFT_W-2:0], 1'b0};
      end
      if (strobe.sample) begin
        capture <= {capture[RD_BITS-2:0], mdioIn};
      end
      if (strobe.finish && isRead) begin
        dataReg[RD_BITS-1:0] <= capture;
      end
    end
  end

  assign serialBit = shiftReg[SHIFT_W-1];
  assign isRead    = (dataReg[DATA_W-3:DATA_W-4] == OP_READ);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_master_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int FRAME_BITS = 64,
  parameter int RELEASE_IDX = 47,
  parameter int SAMPLE_FIRST = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             mgmtEn,
  input  logic [DIV_W-1:0] divSet,
  input  logic             isRead,
  input  logic             evtClr,
  output mdioStrobe_t      strobe,
  output logic             busy,
  output logic             mdc,
  output logic             mdioOe,
  output logic             eventFlag
);
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic [DIV_W-1:0] divLatched;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitIdx;
  logic accept, halfTick, riseNow, fallNow, lastBit;

  assign accept   = startReq && mgmtEn && (divSet != '0) && !busy;
  assign halfTick = busy && (divCnt == divLatched - DIV_W'(1));
  assign riseNow  = halfTick && !mdc;
  assign fallNow  = halfTick && mdc;
  assign lastBit  = (bitIdx == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    strobe.load    = accept;
    strobe.advance = fallNow && !lastBit;
    strobe.sample  = riseNow && isRead && (bitIdx >= BIT_W'(SAMPLE_FIRST));
    strobe.finish  = fallNow && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      mdc        <= 1'b0;
      divCnt     <= '0;
      divLatched <= '0;
      bitIdx     <= '0;
      eventFlag  <= 1'b0;
    end else begin
      if (accept) begin
        busy       <= 1'b1;
        mdc        <= 1'b0;
        divCnt     <= '0;
        divLatched <= divSet;
        bitIdx     <= '0;
      end else if (busy) begin
        if (halfTick) begin
          divCnt <= '0;
          mdc    <= !mdc;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
        if (strobe.advance) bitIdx <= bitIdx + BIT_W'(1);
        if (strobe.finish)  busy   <= 1'b0;
      end
      if (strobe.finish)  eventFlag <= 1'b1;
      else if (evtClr)    eventFlag <= 1'b0;
    end
  end

  assign mdioOe = busy && !(isRead && (bitIdx >= BIT_W'(RELEASE_IDX)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W = 6,
  parameter int PRE_LEN = 32,
  parameter int RD_BITS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  localparam int FRAME_BITS   = PRE_LEN + DATA_W;
  localparam int SAMPLE_FIRST = FRAME_BITS - RD_BITS;
  localparam int RELEASE_IDX  = SAMPLE_FIRST - 1;

  logic             mgmtEn;
  logic [DIV_W-1:0] divSet;
  logic             busy, eventFlag, isRead, serialBit;
  logic [DATA_W-1:0] dataReg;
  mdioStrobe_t      strobe;
  logic             startReq, evtClr;

  assign startReq = regWrEn && (regAddr == ADDR_DATA);
  assign evtClr   = regWrEn && (regAddr == ADDR_EVENT) && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mgmtEn <= 1'b0;
      divSet <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_CTRL)  mgmtEn <= regWrData[0];
      if (regAddr == ADDR_SPEED) divSet <= regWrData[DIV_W:1];
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdData = {{(DATA_W-1){1'b0}}, mgmtEn};
      ADDR_EVENT: regRdData = {{(DATA_W-2){1'b0}}, busy, eventFlag};
      ADDR_SPEED: regRdData = {{(DATA_W-DIV_W-1){1'b0}}, divSet, 1'b0};
      default:    regRdData = dataReg;
    endcase
  end

  mdio_ctrl #(
    .DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS),
    .RELEASE_IDX(RELEASE_IDX), .SAMPLE_FIRST(SAMPLE_FIRST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .mgmtEn(mgmtEn),
    .divSet(divSet), .isRead(isRead), .evtClr(evtClr), .strobe(strobe),
    .busy(busy), .mdc(mdc), .mdioOe(mdioOe), .eventFlag(eventFlag)
  );

  mdio_datapath #(
    .DATA_W(DATA_W), .PRE_LEN(PRE_LEN), .RD_BITS(RD_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWord(regWrData),
    .mdioIn(mdioIn), .dataReg(dataReg), .serialBit(serialBit),
    .isRead(isRead)
  );

  assign mdioOut = serialBit;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_master_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic              busy,
  input logic              eventFlag,
  input logic              mgmtEn,
  input logic [DIV_W-1:0]  divSet
);
  logic dataWr;
  assign dataWr = regWrEn && (regAddr == ADDR_DATA);

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && mgmtEn && divSet != '0 && !busy) |=> busy);

  assert_idle_mdc_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  assert_mdio_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && mdioOut != $past(mdioOut)) |-> $fell(mdc));

  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  assert_done_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> eventFlag);

  assert_event_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && !(regWrEn && regAddr == ADDR_EVENT && regWrData[0])) |=> eventFlag);

  assert_disabled_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !mgmtEn && !busy) |=> !busy);

  assert_zero_div_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && divSet == '0 && !busy) |=> !busy);
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busy(busy), .eventFlag(eventFlag), .mgmtEn(mgmtEn), .divSet(divSet)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0;
  int fails = 0;

  // speed[55:48], phyData[47:32], cmd[31:0]
  localparam int NVEC = 4;
  localparam logic [55:0] VECS [NVEC] = '{
    56'h01A5C3608A0000,
    56'h02000051921234,
    56'h0580016FFE0000,
    56'h0300005002FFFF
  };

  mdio_master u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #10 clk = ~clk;

  // frame monitor and PHY responder
  logic [63:0] seenBits, seenOe;
  int   rises = 0;
  int   highCnt = 0;
  logic prevMdc = 1'b0;
  logic [15:0] phyWord = '0;

  always @(negedge clk) begin
    if (mdc) highCnt++;
    if (mdc && !prevMdc && rises < 64) begin
      seenBits[63-rises] = mdioOut;
      seenOe[63-rises]   = mdioOe;
      rises++;
    end
    prevMdc = mdc;
  end

  always_comb begin
    if (rises >= 48 && rises < 64) mdioIn = phyWord[63-rises];
    else mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // run one frame; optionally poke the data register mid-frame (R12)
  task automatic runFrame(input logic [31:0] cmd, input int spd, input logic [15:0] phy,
                          input bit midWrite);
    logic [31:0] rd;
    logic [63:0] expBits, expOe, mask;
    bit isRd;
    int n;
    bit busyNow;
    isRd = (cmd[29:28] == 2'b10);
    regWrite(2'd2, 32'(spd) << 1);
    phyWord = phy;
    rises = 0; highCnt = 0;
    @(negedge clk);
    regAddr = 2'd3; regWrData = cmd; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd1;
    n = 0;
    busyNow = 1'b1;
    while (busyNow && n < 20000) begin
      if (regAddr == 2'd1) begin
        #1 busyNow = regRdData[1];
      end else busyNow = 1'b1;
      if (busyNow) begin
        n++;
        if (midWrite && n == 100) begin
          regAddr = 2'd3; regWrData = 32'h5000_1111; regWrEn = 1'b1;
        end else begin
          regWrEn = 1'b0; regAddr = 2'd1;
        end
        @(negedge clk);
      end
    end
    regWrEn = 1'b0;
    check(n == 128 * spd, "R8 busy length", 64'(n), 64'(128 * spd));
    check(highCnt == 64 * spd, "R4 mdc high time", 64'(highCnt), 64'(64 * spd));
    expBits = {32'hFFFF_FFFF, cmd};
    expOe = isRd ? {47'h7FFF_FFFF_FFFF, 17'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
    mask = expOe;
    check(rises == 64, "R5 bit count", 64'(rises), 64'd64);
    check((seenBits & mask) == (expBits & mask), "R5 serial bits", seenBits & mask, expBits & mask);
    check(seenOe == expOe, "R6 output enable", seenOe, expOe);
    regRead(2'd1, rd);
    check(rd[1:0] == 2'b01, "R8 event set busy clear", 64'(rd[1:0]), 64'h1);
    check(mdc == 1'b0, "R4 mdc idle low", 64'(mdc), 64'h0);
    regRead(2'd3, rd);
    if (isRd)
      check(rd == {cmd[31:16], phy}, "R7 read data", 64'(rd), 64'({cmd[31:16], phy}));
    else
      check(rd == cmd, midWrite ? "R12 data kept" : "R3 data stored", 64'(rd), 64'(cmd));
    regWrite(2'd1, 32'h0);
    regRead(2'd1, rd);
    check(rd[0] == 1'b1, "R9 write zero keeps event", 64'(rd[0]), 64'h1);
    regWrite(2'd1, 32'h1);
    regRead(2'd1, rd);
    check(rd[0] == 1'b0, "R9 write one clears event", 64'(rd[0]), 64'h0);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd);
      check(rd == 32'h0, "R1 register reset", 64'(rd), 64'h0);
    end
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 pins reset", {62'h0, mdc, mdioOe}, 64'h0);

    // R2 speed field masking
    regWrite(2'd2, 32'hFFFF_FFFF);
    regRead(2'd2, rd);
    check(rd == 32'h7E, "R2 speed field", 64'(rd), 64'h7E);

    // R10 disabled: ignored
    regWrite(2'd3, 32'h6002_0000);
    repeat (5) @(negedge clk);
    regRead(2'd1, rd);
    check(rd[1] == 1'b0, "R10 no start when disabled", 64'(rd[1]), 64'h0);
    regRead(2'd3, rd);
    check(rd == 32'h0, "R10 data unchanged", 64'(rd), 64'h0);

    regWrite(2'd0, 32'h1);
    regRead(2'd0, rd);
    check(rd == 32'h1, "R2 control enable", 64'(rd), 64'h1);

    // R11 zero divider: ignored
    regWrite(2'd2, 32'h0);
    regWrite(2'd3, 32'h6002_0000);
    repeat (5) @(negedge clk);
    regRead(2'd1, rd);
    check(rd[1] == 1'b0 && mdc == 1'b0, "R11 no start with zero divider", {62'h0, rd[1], mdc}, 64'h0);
    regRead(2'd3, rd);
    check(rd == 32'h0, "R11 data unchanged", 64'(rd), 64'h0);

    // table of frames
    for (int i = 0; i < NVEC; i++) begin
      runFrame(VECS[i][31:0], int'(VECS[i][55:48]), VECS[i][47:32], 1'b0);
    end

    // R12 write during busy is ignored
    runFrame(32'h6086_0000, 2, 16'h3C5A, 1'b1);
    runFrame(32'h5086_00AA, 1, 16'h0000, 1'b1);

    report();
  end
endmodule